// File: doc/BRIEF.md
# Polling Receiver Sleep Sequencer

This block controls when a polled radio receiver is awake. It loops through three phases without end: a long low-power sleep, a short startup during which the analog front end settles, and a bitcheck that lasts until an external checker reports pass or fail. A failed bitcheck sends the loop back to sleep. A passed bitcheck moves the block to a receive phase, which it holds until the surrounding logic reports that the reception has ended.

All timing counts ticks of a function clock. The block makes this clock by dividing the crystal clock by 8, 4, 2 or 1, as chosen by a two-bit rate selector. The sleep length comes from a 5-bit code, a unit length and an extension factor of 8. The extension is applied always when the fixed extension bit is set. When the conditional extension bit is set, it is applied only until the first failed bitcheck clears that bit. The all-ones sleep code holds the receiver asleep until a different code is written.

Configuration is a plain parallel load, taken on any cycle with `cfg_we` high. A load that happens during sleep restarts the sleep count.

Top module: `poll_sequencer`

## Requirements
- R1: While `rst` is high and just after it falls, `phase` is 0 (sleep), `fe_enable` and `rx_active` are 0, and `ext_tmp_active` is 0.
- R2: `fclk_tick` pulses once every 8, 4, 2 or 1 clock cycles for `cfg_range` values 0, 1, 2 and 3.
- R3: Phases are encoded 0 sleep, 1 startup, 2 bitcheck, 3 receive. Sleep is always followed by startup, and startup by bitcheck. `fe_enable` is 0 exactly in sleep.
- R4: A sleep lasts code × UNIT_TICKS × F ticks, with at least 1 tick, where F is 1 without extension. The count starts when sleep is entered or at the last load made during sleep.
- R5: Startup lasts STARTUP_TICKS ticks.
- R6: Bitcheck ends only on a cycle with `bc_done` high. If `bc_pass` is 0 on that cycle, the next phase is sleep.
- R7: A pass moves the block to receive (phase 3, `rx_active` 1, `fe_enable` 1). It stays there until `rx_end` is high, and then goes to sleep.
- R8: With the fixed extension bit set, every sleep uses F = 8.
- R9: With the conditional extension bit set, sleeps use F = 8 while bitchecks pass. The first failed bitcheck clears the bit (`ext_tmp_active` falls to 0) and later sleeps use F = 1.
- R10: Sleep code 31 keeps the block in sleep for as long as the code stays 31. Loading another code starts a normal sleep counted from that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crystal-derived clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | load the four configuration fields |
| cfg_sleep | input | SLEEP_W | sleep code |
| cfg_range | input | 2 | rate selector for the function-clock divider |
| cfg_ext_std | input | 1 | fixed sleep extension |
| cfg_ext_tmp | input | 1 | conditional sleep extension |
| bc_done | input | 1 | bitcheck finished strobe |
| bc_pass | input | 1 | bitcheck result, qualified by bc_done |
| rx_end | input | 1 | end of reception |
| phase | output | 2 | current phase code |
| fe_enable | output | 1 | front-end enable |
| rx_active | output | 1 | receive phase active |
| fclk_tick | output | 1 | function-clock tick enable |
| ext_tmp_active | output | 1 | state of the conditional extension bit |

## Verification
The bench counts ticks across every sleep and startup and compares each sleep against a queue of expected lengths. An off-by-one terminal compare would therefore show up as a length one tick too long or too short. A load made during sleep must restart the count; a design that ignored the load would wake early, and the count after the release from code 31 would be wrong. The bench follows the conditional extension across a pass, a reception and a failure. A design that cleared the bit on a pass, or left it set after a failure, would produce a 32-tick sleep where 4 are expected (or the reverse). Divider spacing is measured at all four rates, and the bench checks that bitcheck waits for the strobe.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP   = 2'd0,
    PH_STARTUP = 2'd1,
    PH_CHECK   = 2'd2,
    PH_RECV    = 2'd3
  } phase_t;

  localparam int unsigned EXT_FACTOR = 8;

  // crystal cycles per function-clock tick
  function automatic int unsigned div_ratio(input logic [1:0] rng);
    return 32'd8 >> rng;
  endfunction

  // sleep length in function-clock ticks
  function automatic int unsigned sleep_ticks(input int unsigned code,
                                              input logic ext,
                                              input int unsigned unit);
    return code * unit * (ext ? EXT_FACTOR : 32'd1);
  endfunction

endpackage

// File: rtl/poll_tick_gen.sv
module poll_tick_gen
  import poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rng,
  output logic       tick
);
  logic [2:0] div_cnt;
  logic [2:0] last_cnt;

  always_comb begin
    last_cnt = 3'(div_ratio(rng) - 1);
    tick     = (div_cnt >= last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 3'd1;
  end

  // R2: below full rate, two ticks never come back to back unless the rate changed
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && rng != 2'd3) |=> (!tick || rng != $past(rng)));

endmodule

// File: rtl/poll_cfg_regs.sv
module poll_cfg_regs #(
  parameter int SLEEP_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SLEEP_W-1:0] wr_sleep,
  input  logic [1:0]         wr_range,
  input  logic               wr_ext_std,
  input  logic               wr_ext_tmp,
  input  logic               fail_evt,
  output logic [SLEEP_W-1:0] sleep_code,
  output logic [1:0]         rng,
  output logic               ext_on,
  output logic               ext_tmp
);
  logic ext_std;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_code <= '0;
      rng        <= '0;
      ext_std    <= 1'b0;
      ext_tmp    <= 1'b0;
    end else if (we) begin
      sleep_code <= wr_sleep;
      rng        <= wr_range;
      ext_std    <= wr_ext_std;
      ext_tmp    <= wr_ext_tmp;
    end else if (fail_evt) begin
      ext_tmp    <= 1'b0;
    end
  end

  assign ext_on = ext_std | ext_tmp;

  // R9: a failed bitcheck clears the conditional extension
  a_r9_tmp_clears: assert property (@(posedge clk) disable iff (rst)
    (fail_evt && !we) |=> !ext_tmp);

endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_pkg::*;
#(
  parameter int SLEEP_W       = 5,
  parameter int UNIT_TICKS    = 1024,
  parameter int STARTUP_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               cfg_we,
  input  logic [SLEEP_W-1:0] sleep_code,
  input  logic               ext_on,
  input  logic               bc_done,
  input  logic               bc_pass,
  input  logic               rx_end,
  output phase_t             state,
  output logic               fail_evt
);
  localparam int CNT_W = SLEEP_W + $clog2(UNIT_TICKS) + 4;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] sleep_target;
  logic             perm_sleep;
  logic             sleep_over;
  logic             startup_over;

  always_comb begin
    cnt_inc      = cnt + 1'b1;
    sleep_target = CNT_W'(sleep_ticks(32'(sleep_code), ext_on, UNIT_TICKS));
    perm_sleep   = &sleep_code;
    sleep_over   = tick && !perm_sleep && (cnt_inc >= sleep_target);
    startup_over = tick && (cnt_inc >= CNT_W'(STARTUP_TICKS));
    fail_evt     = (state == PH_CHECK) && bc_done && !bc_pass;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_SLEEP;
      cnt   <= '0;
    end else begin
      unique case (state)
        PH_SLEEP: begin
          if (cfg_we)          cnt <= '0;
          else if (sleep_over) begin
            state <= PH_STARTUP;
            cnt   <= '0;
          end else if (tick && !perm_sleep) cnt <= cnt_inc;
        end
        PH_STARTUP: begin
          if (startup_over) begin
            state <= PH_CHECK;
            cnt   <= '0;
          end else if (tick) cnt <= cnt_inc;
        end
        PH_CHECK: begin
          if (bc_done) begin
            state <= bc_pass ? PH_RECV : PH_SLEEP;
            cnt   <= '0;
          end
        end
        PH_RECV: begin
          if (rx_end) begin
            state <= PH_SLEEP;
            cnt   <= '0;
          end
        end
        default: state <= PH_SLEEP;
      endcase
    end
  end

  // R4: sleep ends only on a tick
  a_r4_wake_on_tick: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SLEEP && !tick) |=> state == PH_SLEEP);
  // R10: all-ones code holds sleep until a load
  a_r10_perm_sleep: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SLEEP && perm_sleep && !cfg_we) |=> state == PH_SLEEP);
  // R6: bitcheck waits for the done strobe
  a_r6_wait_done: assert property (@(posedge clk) disable iff (rst)
    (state == PH_CHECK && !bc_done) |=> state == PH_CHECK);
  // R6: failure returns to sleep
  a_r6_fail_sleep: assert property (@(posedge clk) disable iff (rst)
    fail_evt |=> state == PH_SLEEP);
  // R7: receive holds until end of reception
  a_r7_recv_hold: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RECV && !rx_end) |=> state == PH_RECV);
  // R3: startup only follows sleep
  a_r3_order: assert property (@(posedge clk) disable iff (rst)
    (state == PH_STARTUP && $past(state) != PH_STARTUP) |-> $past(state) == PH_SLEEP);

endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer
  import poll_pkg::*;
#(
  parameter int SLEEP_W       = 5,
  parameter int UNIT_TICKS    = 1024,
  parameter int STARTUP_TICKS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SLEEP_W-1:0] cfg_sleep,
  input  logic [1:0]         cfg_range,
  input  logic               cfg_ext_std,
  input  logic               cfg_ext_tmp,
  input  logic               bc_done,
  input  logic               bc_pass,
  input  logic               rx_end,
  output logic [1:0]         phase,
  output logic               fe_enable,
  output logic               rx_active,
  output logic               fclk_tick,
  output logic               ext_tmp_active
);
  logic [SLEEP_W-1:0] sleep_code;
  logic [1:0]         rng;
  logic               ext_on;
  logic               fail_evt;
  phase_t             state;

  poll_cfg_regs #(.SLEEP_W(SLEEP_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we),
    .wr_sleep(cfg_sleep), .wr_range(cfg_range),
    .wr_ext_std(cfg_ext_std), .wr_ext_tmp(cfg_ext_tmp),
    .fail_evt(fail_evt),
    .sleep_code(sleep_code), .rng(rng), .ext_on(ext_on), .ext_tmp(ext_tmp_active)
  );

  poll_tick_gen u_tick (
    .clk(clk), .rst(rst), .rng(rng), .tick(fclk_tick)
  );

  poll_fsm #(
    .SLEEP_W(SLEEP_W), .UNIT_TICKS(UNIT_TICKS), .STARTUP_TICKS(STARTUP_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick(fclk_tick), .cfg_we(cfg_we),
    .sleep_code(sleep_code), .ext_on(ext_on),
    .bc_done(bc_done), .bc_pass(bc_pass), .rx_end(rx_end),
    .state(state), .fail_evt(fail_evt)
  );

  assign phase     = state;
  assign fe_enable = (state != PH_SLEEP);
  assign rx_active = (state == PH_RECV);

  // R3: front end is off right after a failure and on right after a pass
  a_r3_fe_after_fail: assert property (@(posedge clk) disable iff (rst)
    fail_evt |=> !fe_enable);
  a_r7_rx_after_pass: assert property (@(posedge clk) disable iff (rst)
    (state == PH_CHECK && bc_done && bc_pass) |=> (rx_active && fe_enable));

endmodule

// File: tb/tb_poll_sequencer.sv
module tb_poll_sequencer;
  localparam int UNIT = 4;
  localparam int SU   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_ext_std = 1'b0, cfg_ext_tmp = 1'b0;
  logic [4:0] cfg_sleep = '0;
  logic [1:0] cfg_range = '0;
  logic bc_done = 1'b0, bc_pass = 1'b0, rx_end = 1'b0;
  logic [1:0] phase;
  logic fe_enable, rx_active, fclk_tick, ext_tmp_active;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  int slp_cnt = 0, su_cnt = 0;
  logic [1:0] prev_ph = 2'd0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  poll_sequencer #(.SLEEP_W(5), .UNIT_TICKS(UNIT), .STARTUP_TICKS(SU)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sleep(cfg_sleep),
    .cfg_range(cfg_range), .cfg_ext_std(cfg_ext_std), .cfg_ext_tmp(cfg_ext_tmp),
    .bc_done(bc_done), .bc_pass(bc_pass), .rx_end(rx_end),
    .phase(phase), .fe_enable(fe_enable), .rx_active(rx_active),
    .fclk_tick(fclk_tick), .ext_tmp_active(ext_tmp_active));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: measures every sleep and startup
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ph == 2'd0 && phase == 2'd1) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected wake", slp_cnt, -1);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(slp_cnt == e, t, slp_cnt, e);
        end
        su_cnt = 0;
      end
      if (prev_ph == 2'd0 && phase != 2'd0 && phase != 2'd1)
        check(1'b0, "R3 sleep not followed by startup", phase, 1);
      if (prev_ph == 2'd1 && phase != 2'd1) begin
        check(phase == 2'd2, "R3 startup followed by bitcheck", phase, 2);
        check(su_cnt == SU, "R5 startup ticks", su_cnt, SU);
      end
      if (prev_ph != 2'd0 && phase == 2'd0) slp_cnt = 0;
      if (phase == 2'd0) begin
        if (cfg_we) slp_cnt = 0;
        else if (fclk_tick) slp_cnt++;
      end
      if (phase == 2'd1 && fclk_tick) su_cnt++;
      prev_ph = phase;
    end
  end

  task automatic load(input int code, input int rng_v, input bit s, input bit t);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sleep = 5'(code); cfg_range = 2'(rng_v);
    cfg_ext_std = s; cfg_ext_tmp = t;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic expect_sleep(input int ticks, input string tag);
    exp_q.push_back(ticks);
    tag_q.push_back(tag);
  endtask

  task automatic wait_phase(input int p);
    @(negedge clk);
    while (phase != 2'(p)) @(negedge clk);
  endtask

  task automatic bitcheck(input bit pass);
    @(posedge clk); #1;
    bc_done = 1'b1; bc_pass = pass;
    @(posedge clk); #1;
    bc_done = 1'b0; bc_pass = 1'b0;
  endtask

  task automatic spacing(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!fclk_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!fclk_tick);
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(phase == 2'd0, "R1 reset phase", phase, 0);
    check(fe_enable == 1'b0, "R1 reset fe_enable", fe_enable, 0);
    check(rx_active == 1'b0, "R1 reset rx_active", rx_active, 0);
    check(ext_tmp_active == 1'b0, "R1 reset ext_tmp", ext_tmp_active, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(phase == 2'd0 && !fe_enable, "R1 after reset", phase, 0);

    // basic loop at full rate: code 3 -> 12 ticks
    load(3, 3, 0, 0);
    expect_sleep(12, "R4 sleep code 3");
    wait_phase(2);
    check(fe_enable == 1'b1, "R3 fe on in bitcheck", fe_enable, 1);
    repeat (10) @(negedge clk);
    check(phase == 2'd2, "R6 bitcheck waits for done", phase, 2);
    expect_sleep(12, "R6 fail returns to sleep");
    bitcheck(1'b0);
    @(negedge clk);
    check(phase == 2'd0 && !fe_enable, "R6 sleep after fail", phase, 0);
    spacing(1, "R2 range 3 spacing");
    wait_phase(2);

    // rate 1, code 2 -> 8 ticks; load restarts the count
    bitcheck(1'b0);
    load(2, 1, 0, 0);
    expect_sleep(8, "R4 sleep code 2 after load");
    spacing(4, "R2 range 1 spacing");
    wait_phase(2);

    // fixed extension: 2*4*8 = 64, twice
    bitcheck(1'b0);
    load(2, 1, 1, 0);
    expect_sleep(64, "R8 extended sleep");
    wait_phase(2);
    expect_sleep(64, "R8 extension persists");
    bitcheck(1'b0);
    wait_phase(2);

    // conditional extension
    bitcheck(1'b0);
    load(1, 3, 0, 1);
    expect_sleep(32, "R9 conditional extension active");
    wait_phase(2);
    bitcheck(1'b1);
    @(negedge clk);
    check(phase == 2'd3, "R7 receive phase", phase, 3);
    check(rx_active && fe_enable, "R7 rx_active and fe", rx_active, 1);
    check(ext_tmp_active == 1'b1, "R9 bit kept on pass", ext_tmp_active, 1);
    repeat (20) @(negedge clk);
    check(phase == 2'd3, "R7 holds until rx_end", phase, 3);
    expect_sleep(32, "R9 extension after pass");
    @(posedge clk); #1 rx_end = 1'b1;
    @(posedge clk); #1 rx_end = 1'b0;
    @(negedge clk);
    check(phase == 2'd0 && !rx_active, "R7 sleep after rx_end", phase, 0);
    wait_phase(2);
    expect_sleep(4, "R9 normal sleep after failure");
    bitcheck(1'b0);
    @(negedge clk);
    check(ext_tmp_active == 1'b0, "R9 bit cleared on fail", ext_tmp_active, 0);
    wait_phase(2);

    // permanent sleep
    bitcheck(1'b0);
    load(31, 0, 0, 0);
    spacing(8, "R2 range 0 spacing");
    load(31, 2, 0, 0);
    spacing(2, "R2 range 2 spacing");
    repeat (400) @(negedge clk);
    check(phase == 2'd0 && !fe_enable, "R10 permanent sleep", phase, 0);
    expect_sleep(8, "R10 release counts from load");
    load(2, 3, 0, 0);
    wait_phase(2);
    check(exp_q.size() == 0, "R4 all sleeps observed", exp_q.size(), 0);
    summary();
  end
endmodule